// File: doc/BRIEF.md
# Display Timing Generator with Frame-End Register Update

This block drives the raster timing of a parallel video output. It produces horizontal sync, vertical sync, a data-enable strobe, and the column and row of the current pixel inside the visible area. Software programs porches, sync widths, visible size and sync polarity through a single-cycle register write port. These timing writes land in a shadow set. They reach the live set that drives the counters only at the end of a frame, after software has armed the transfer with a flush write and while the engine runs. A retimed video mode therefore never produces a torn frame.

A one-cycle frame-end pulse marks the first clock after the last visible pixel. The same event sets an interrupt status bit. Software masks that bit with an enable and clears it by writing one. A control register holds the run enable, a data gate and an output pixel-depth field, and it acts at once.

Each axis is driven by one phase sequencer, a four-state machine: PH_SYNC, PH_BACK, PH_ACT and PH_FRONT. The transitions are as follows:
- PH_SYNC goes to PH_BACK, or straight to PH_ACT when the back porch is zero.
- PH_BACK goes to PH_ACT.
- PH_ACT goes to PH_FRONT, or wraps to PH_SYNC when the front porch is zero.
- PH_FRONT wraps to PH_SYNC.

Each state lasts its programmed count of steps. The horizontal machine steps every clock. The vertical machine steps once per horizontal wrap. Clearing the run enable forces both machines back to PH_SYNC with a zero count.

Top module: `display_timing_gen`

## Requirements
- R1: After reset the engine is stopped. de_o, hsync_o, vsync_o, frame_end_o and irq_o are all low, and bpp_o is 0.
- R2: Each line runs sync, then back porch, then visible, then front porch. Each frame runs the same four phases counted in lines. One frame lasts (line total) x (frame total) clocks. de_o is high only when both axes are in the visible phase.
- R3: Address 0x0 holds the horizontal porches, with the back porch in bits [27:16] and the front porch in bits [11:0]. Address 0x2 packs the vertical porches the same way. Address 0x1 holds the horizontal sync width minus one, and address 0x3 holds the vertical sync width minus one. Address 0x4 holds height minus one in bits [27:16] and width minus one in bits [11:0]. A porch of zero removes that phase.
- R4: The vertical sync width saturates at 15 lines. A code written to 0x3 above 14 is stored as 14.
- R5: At address 0x5, bit 0 inverts vsync_o and bit 1 inverts hsync_o. When a sync is inverted, it idles high and pulses low.
- R6: Writes to addresses 0x0 to 0x5 leave the output unchanged until a write of bit 0 = 1 to address 0x7 arms a transfer. The shadow set then becomes live at the next frame end, in the frame-end cycle itself. A frame end only occurs while the engine runs.
- R7: frame_end_o is a one-cycle pulse in the clock right after the visible pixel at column width-1 of row height-1.
- R8: Every frame end sets an interrupt status bit. irq_o is that status ANDed with address 0x8 bit 0. Writing 1 to address 0x9 bit 0 clears the status.
- R9: Address 0x6 takes effect on the next clock: bit 0 is the run enable, bit 1 the data gate, and bits [5:4] drive bpp_o. With the gate clear, de_o stays low while the syncs and frame_end_o continue.
- R10: With the run enable clear, de_o and frame_end_o stay low and both syncs stay at their inactive level.
- R11: While de_o is high, pix_x_o and pix_y_o give the column and row inside the visible area, counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync at the programmed polarity |
| vsync_o | output | 1 | Vertical sync at the programmed polarity |
| de_o | output | 1 | Data enable, high on visible pixels |
| pix_x_o | output | 12 | Visible column |
| pix_y_o | output | 12 | Visible row |
| frame_end_o | output | 1 | One-cycle frame-end pulse |
| irq_o | output | 1 | Masked frame-end interrupt |
| bpp_o | output | 2 | Output pixel-depth field |

## Verification
The assertions assume that the live timing changes only through an armed frame-end transfer. They also assume that every programmed field fits its width, so that the visible counters never exceed the live limits. The stimulus writes one mapped register at a time, away from the clock edge. It reprograms timing only through the shadow set with a flush, and it measures only whole frames that start after the transfer. This keeps frames that mix old and new timing out of every expected count.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CW    = 12;
    localparam int VSW_W = 4;
    localparam int AW    = 4;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CW-1:0]    h_back;
        logic [CW-1:0]    h_front;
        logic [CW-1:0]    h_sync_m1;
        logic [CW-1:0]    h_act_m1;
        logic [CW-1:0]    v_back;
        logic [CW-1:0]    v_front;
        logic [CW-1:0]    v_act_m1;
        logic [VSW_W-1:0] v_sync_m1;
        logic             inv_v;
        logic             inv_h;
    } timing_t;

    localparam logic [AW-1:0] A_HPORCH = 4'h0;
    localparam logic [AW-1:0] A_HSYNC  = 4'h1;
    localparam logic [AW-1:0] A_VPORCH = 4'h2;
    localparam logic [AW-1:0] A_VSYNC  = 4'h3;
    localparam logic [AW-1:0] A_SIZE   = 4'h4;
    localparam logic [AW-1:0] A_POL    = 4'h5;
    localparam logic [AW-1:0] A_CTRL   = 4'h6;
    localparam logic [AW-1:0] A_FLUSH  = 4'h7;
    localparam logic [AW-1:0] A_IRQEN  = 4'h8;
    localparam logic [AW-1:0] A_IRQCLR = 4'h9;

    localparam logic [CW-1:0] VSYNC_MAX_M1 = CW'(14);

endpackage

// File: rtl/dtg_phase_seq.sv
module dtg_phase_seq
    import dtg_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          step_i,
    input  logic [CW-1:0] sync_last_i,
    input  logic [CW-1:0] back_len_i,
    input  logic [CW-1:0] act_last_i,
    input  logic [CW-1:0] front_len_i,
    output phase_e        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic          at_last_o,
    output logic          wrap_o
);

    localparam logic [CW:0] ONE_X = (CW+1)'(1);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          at_last;

    always_comb begin
        at_last = 1'b0;
        unique case (phase_q)
            PH_SYNC:  at_last = cnt_q >= sync_last_i;
            PH_BACK:  at_last = ({1'b0, cnt_q} + ONE_X) >= {1'b0, back_len_i};
            PH_ACT:   at_last = cnt_q >= act_last_i;
            PH_FRONT: at_last = ({1'b0, cnt_q} + ONE_X) >= {1'b0, front_len_i};
        endcase
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!run_i) begin
            phase_d = PH_SYNC;
            cnt_d   = '0;
        end else if (step_i) begin
            if (at_last) begin
                cnt_d = '0;
                unique case (phase_q)
                    PH_SYNC:  phase_d = (back_len_i != '0) ? PH_BACK : PH_ACT;
                    PH_BACK:  phase_d = PH_ACT;
                    PH_ACT:   phase_d = (front_len_i != '0) ? PH_FRONT : PH_SYNC;
                    PH_FRONT: phase_d = PH_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase_o   = phase_q;
        cnt_o     = cnt_q;
        at_last_o = at_last;
        wrap_o    = run_i && step_i && at_last &&
                    ((phase_q == PH_FRONT) ||
                     ((phase_q == PH_ACT) && (front_len_i == '0)));
    end

endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
#(
    parameter timing_t RST_T = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [31:0]   wr_data_i,
    input  logic          load_i,
    output timing_t       live_o,
    output timing_t       shadow_o,
    output logic          armed_o,
    output logic          run_o,
    output logic          gate_o,
    output logic [1:0]    bpp_o,
    output logic          irq_en_o,
    output logic          irq_clr_o
);

    timing_t       shadow_q, live_q;
    logic          armed_q, run_q, gate_q, irq_en_q;
    logic [1:0]    bpp_q;
    logic          flush_wr;
    logic [CW-1:0] vs_req;
    logic [VSW_W-1:0] vs_code;
    logic          unused_data;

    assign flush_wr  = wr_en_i && (wr_addr_i == A_FLUSH) && wr_data_i[0];
    assign irq_clr_o = wr_en_i && (wr_addr_i == A_IRQCLR) && wr_data_i[0];
    assign vs_req    = wr_data_i[CW-1:0];
    assign vs_code   = (vs_req > VSYNC_MAX_M1) ? VSYNC_MAX_M1[VSW_W-1:0]
                                               : vs_req[VSW_W-1:0];
    assign unused_data = ^{wr_data_i[31:16+CW], wr_data_i[15:CW]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shadow_q <= RST_T;
            live_q   <= RST_T;
            armed_q  <= 1'b0;
            run_q    <= 1'b0;
            gate_q   <= 1'b0;
            bpp_q    <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (load_i) begin
                live_q <= shadow_q;
            end
            armed_q <= (armed_q && !load_i) || flush_wr;
            if (wr_en_i) begin
                case (wr_addr_i)
                    A_HPORCH: begin
                        shadow_q.h_back  <= wr_data_i[16 +: CW];
                        shadow_q.h_front <= wr_data_i[0 +: CW];
                    end
                    A_HSYNC:  shadow_q.h_sync_m1 <= wr_data_i[0 +: CW];
                    A_VPORCH: begin
                        shadow_q.v_back  <= wr_data_i[16 +: CW];
                        shadow_q.v_front <= wr_data_i[0 +: CW];
                    end
                    A_VSYNC:  shadow_q.v_sync_m1 <= vs_code;
                    A_SIZE: begin
                        shadow_q.v_act_m1 <= wr_data_i[16 +: CW];
                        shadow_q.h_act_m1 <= wr_data_i[0 +: CW];
                    end
                    A_POL: begin
                        shadow_q.inv_v <= wr_data_i[0];
                        shadow_q.inv_h <= wr_data_i[1];
                    end
                    A_CTRL: begin
                        run_q  <= wr_data_i[0];
                        gate_q <= wr_data_i[1];
                        bpp_q  <= wr_data_i[5:4];
                    end
                    A_IRQEN: irq_en_q <= wr_data_i[0];
                    default: ;
                endcase
            end
        end
    end

    assign live_o   = live_q;
    assign shadow_o = shadow_q;
    assign armed_o  = armed_q;
    assign run_o    = run_q;
    assign gate_o   = gate_q;
    assign bpp_o    = bpp_q;
    assign irq_en_o = irq_en_q;

endmodule

// File: rtl/dtg_irq.sv
module dtg_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic irq_o
);

    logic stat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= 1'b0;
        end else begin
            stat_q <= set_i || (stat_q && !clr_i);
        end
    end

    assign irq_o = stat_q && en_i;

endmodule

// File: rtl/display_timing_gen.sv
module display_timing_gen
    import dtg_pkg::*;
#(
    parameter int H_SYNC  = 2,
    parameter int H_BACK  = 3,
    parameter int H_ACT   = 8,
    parameter int H_FRONT = 2,
    parameter int V_SYNC  = 1,
    parameter int V_BACK  = 2,
    parameter int V_ACT   = 4,
    parameter int V_FRONT = 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [3:0]    wr_addr_i,
    input  logic [31:0]   wr_data_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [11:0]   pix_x_o,
    output logic [11:0]   pix_y_o,
    output logic          frame_end_o,
    output logic          irq_o,
    output logic [1:0]    bpp_o
);

    localparam timing_t RST_T = '{
        h_back:    CW'(H_BACK),
        h_front:   CW'(H_FRONT),
        h_sync_m1: CW'(H_SYNC - 1),
        h_act_m1:  CW'(H_ACT - 1),
        v_back:    CW'(V_BACK),
        v_front:   CW'(V_FRONT),
        v_act_m1:  CW'(V_ACT - 1),
        v_sync_m1: VSW_W'(V_SYNC - 1),
        inv_v:     1'b0,
        inv_h:     1'b0
    };

    timing_t       live_w, shadow_w;
    logic          armed_w, run_w, gate_w, irq_en_w, irq_clr_w;
    logic          load_w, fe_cond, fe_q;
    phase_e        h_phase, v_phase;
    logic [CW-1:0] h_cnt, v_cnt;
    logic          h_last, v_last, h_wrap, v_wrap;
    logic          visible;

    dtg_regs #(.RST_T(RST_T)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .load_i    (load_w),
        .live_o    (live_w),
        .shadow_o  (shadow_w),
        .armed_o   (armed_w),
        .run_o     (run_w),
        .gate_o    (gate_w),
        .bpp_o     (bpp_o),
        .irq_en_o  (irq_en_w),
        .irq_clr_o (irq_clr_w)
    );

    dtg_phase_seq u_hseq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run_w),
        .step_i      (1'b1),
        .sync_last_i (live_w.h_sync_m1),
        .back_len_i  (live_w.h_back),
        .act_last_i  (live_w.h_act_m1),
        .front_len_i (live_w.h_front),
        .phase_o     (h_phase),
        .cnt_o       (h_cnt),
        .at_last_o   (h_last),
        .wrap_o      (h_wrap)
    );

    dtg_phase_seq u_vseq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run_w),
        .step_i      (h_wrap),
        .sync_last_i ({{(CW-VSW_W){1'b0}}, live_w.v_sync_m1}),
        .back_len_i  (live_w.v_back),
        .act_last_i  (live_w.v_act_m1),
        .front_len_i (live_w.v_front),
        .phase_o     (v_phase),
        .cnt_o       (v_cnt),
        .at_last_o   (v_last),
        .wrap_o      (v_wrap)
    );

    assign fe_cond = run_w && (h_phase == PH_ACT) && h_last &&
                     (v_phase == PH_ACT) && v_last;
    assign load_w  = fe_cond && armed_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fe_q <= 1'b0;
        end else begin
            fe_q <= fe_cond;
        end
    end

    dtg_irq u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (fe_cond),
        .clr_i  (irq_clr_w),
        .en_i   (irq_en_w),
        .irq_o  (irq_o)
    );

    always_comb begin
        visible     = run_w && (h_phase == PH_ACT) && (v_phase == PH_ACT);
        de_o        = visible && gate_w;
        hsync_o     = (run_w && (h_phase == PH_SYNC)) ^ live_w.inv_h;
        vsync_o     = (run_w && (v_phase == PH_SYNC)) ^ live_w.inv_v;
        pix_x_o     = visible ? h_cnt : '0;
        pix_y_o     = visible ? v_cnt : '0;
        frame_end_o = fe_q;
    end

    logic unused_wrap;
    assign unused_wrap = v_wrap;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
(
    input logic          clk_i,
    input logic          rst_ni,
    input logic          run_i,
    input logic          load_i,
    input logic          irq_en_i,
    input logic          de_i,
    input logic          frame_end_i,
    input logic          irq_i,
    input logic [CW-1:0] pix_x_i,
    input logic [CW-1:0] pix_y_i,
    input timing_t       live_i,
    input timing_t       shadow_i
);

    AST_FE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end_i |=> !frame_end_i); // R7

    AST_FE_AFTER_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end_i |-> !de_i); // R7

    AST_LIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(live_i)); // R6

    AST_VSYNC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shadow_i.v_sync_m1 <= VSYNC_MAX_M1[VSW_W-1:0]); // R4

    AST_IRQ_ON_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_end_i && irq_en_i) |-> irq_i); // R8

    AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !de_i); // R10

    AST_STOPPED_NO_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && $past(!run_i)) |-> !frame_end_i); // R10

    AST_PIX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        de_i |-> ((pix_x_i <= live_i.h_act_m1) && (pix_y_i <= live_i.v_act_m1))); // R11

endmodule

bind display_timing_gen dtg_checker i_dtg_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_w),
    .load_i      (load_w),
    .irq_en_i    (irq_en_w),
    .de_i        (de_o),
    .frame_end_i (frame_end_o),
    .irq_i       (irq_o),
    .pix_x_i     (pix_x_o),
    .pix_y_i     (pix_y_o),
    .live_i      (live_w),
    .shadow_i    (shadow_w)
);

// File: tb/test_display_timing_gen.sv
module test_display_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, frame_end, irq;
    logic [11:0] pix_x, pix_y;
    logic [1:0]  bpp;

    always #2.5 clk = ~clk;

    display_timing_gen i_display_timing_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .hsync_o     (hsync),
        .vsync_o     (vsync),
        .de_o        (de),
        .pix_x_o     (pix_x),
        .pix_y_o     (pix_y),
        .frame_end_o (frame_end),
        .irq_o       (irq),
        .bpp_o       (bpp)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit timed_out = 1'b0;

    // expected timing in actual units
    int e_hsw = 2, e_hbp = 3, e_w = 8, e_hfp = 2;
    int e_vsw = 1, e_vbp = 2, e_h = 4, e_vfp = 1;
    int e_invh = 0, e_invv = 0;

    // measurements over one frame
    int m_cyc, m_de, m_hs, m_vs, m_px, m_py, m_pde;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_fe(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_end && n < 4000);
        if (!frame_end) check_eq(req, "frame end seen", 0, 1);
    endtask

    task automatic measure_frame(input string req);
        int n = 0;
        int pde = 0, px = 0, py = 0;
        wait_fe(req);
        m_cyc = 0; m_de = 0; m_hs = 0; m_vs = 0;
        do begin
            pde = int'(de); px = int'(pix_x); py = int'(pix_y);
            @(negedge clk);
            n++;
            m_cyc++;
            if (de) m_de++;
            if (int'(hsync) != e_invh) m_hs++;
            if (int'(vsync) != e_invv) m_vs++;
        end while (!frame_end && n < 4000);
        m_pde = pde; m_px = px; m_py = py;
    endtask

    task automatic check_frame(input string req, input bit gate_on);
        int ht = e_hsw + e_hbp + e_w + e_hfp;
        int vt = e_vsw + e_vbp + e_h + e_vfp;
        check_eq(req, "frame clocks", m_cyc, ht * vt);
        check_eq(req, "de clocks", m_de, gate_on ? e_w * e_h : 0);
        check_eq(req, "hsync active clocks", m_hs, e_hsw * vt);
        check_eq(req, "vsync active clocks", m_vs, e_vsw * ht);
        if (gate_on) begin
            check_eq("R7", "de before frame end", m_pde, 1);
            check_eq("R11", "last column", m_px, e_w - 1);
            check_eq("R11", "last row", m_py, e_h - 1);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_eq("R1", "de", int'(de), 0);
        check_eq("R1", "hsync", int'(hsync), 0);
        check_eq("R1", "vsync", int'(vsync), 0);
        check_eq("R1", "frame_end", int'(frame_end), 0);
        check_eq("R1", "irq", int'(irq), 0);
        check_eq("R1", "bpp", int'(bpp), 0);
    endtask

    task automatic t_default;
        write_reg(4'h6, 32'h23);
        check_eq("R9", "bpp field", int'(bpp), 2);
        measure_frame("R2");
        check_frame("R2", 1'b1);
    endtask

    task automatic t_shadow;
        write_reg(4'h0, (32'd1 << 16) | 32'd1);
        write_reg(4'h1, 32'd0);
        write_reg(4'h2, (32'd1 << 16) | 32'd2);
        write_reg(4'h3, 32'd1);
        write_reg(4'h4, (32'd2 << 16) | 32'd5);
        write_reg(4'h5, 32'd3);
        measure_frame("R6");
        check_frame("R6", 1'b1);
        write_reg(4'h7, 32'd1);
        e_hsw = 1; e_hbp = 1; e_w = 6; e_hfp = 1;
        e_vsw = 2; e_vbp = 1; e_h = 3; e_vfp = 2;
        e_invh = 1; e_invv = 1;
        wait_fe("R6");
        measure_frame("R3");
        check_frame("R3", 1'b1);
        check_eq("R5", "hsync level in visible", int'(hsync), 1);
    endtask

    task automatic t_clamp;
        write_reg(4'h3, 32'd40);
        write_reg(4'h7, 32'd1);
        e_vsw = 15;
        wait_fe("R4");
        measure_frame("R4");
        check_frame("R4", 1'b1);
    endtask

    task automatic t_zero_porch;
        write_reg(4'h0, 32'd0);
        write_reg(4'h7, 32'd1);
        e_hbp = 0; e_hfp = 0;
        wait_fe("R3");
        measure_frame("R3");
        check_frame("R3", 1'b1);
    endtask

    task automatic t_gate;
        write_reg(4'h6, 32'h21);
        measure_frame("R9");
        check_frame("R9", 1'b0);
    endtask

    task automatic t_irq;
        wait_fe("R8");
        check_eq("R8", "irq masked", int'(irq), 0);
        write_reg(4'h8, 32'd1);
        check_eq("R8", "irq after unmask", int'(irq), 1);
        write_reg(4'h9, 32'd1);
        check_eq("R8", "irq after clear", int'(irq), 0);
        wait_fe("R8");
        check_eq("R8", "irq at frame end", int'(irq), 1);
    endtask

    task automatic t_stop;
        int n_de = 0, n_fe = 0, n_hs = 0, n_vs = 0;
        write_reg(4'h6, 32'h0);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (de) n_de++;
            if (frame_end) n_fe++;
            if (int'(hsync) != e_invh) n_hs++;
            if (int'(vsync) != e_invv) n_vs++;
        end
        check_eq("R10", "de while stopped", n_de, 0);
        check_eq("R10", "frame_end while stopped", n_fe, 0);
        check_eq("R10", "hsync active while stopped", n_hs, 0);
        check_eq("R10", "vsync active while stopped", n_vs, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_default();
                t_shadow();
                t_clamp();
                t_zero_porch();
                t_gate();
                t_irq();
                t_stop();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule